// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends characters on an asynchronous serial line. Software writes a character through a register-style write port into a single holding register. As soon as the internal shift register is free, the character moves into it. The block then drives one start bit, the data bits least significant first, and one stop bit. Each bit is held for one pulse of an externally supplied baud-rate enable.

Two flags report buffer state. A holding-empty flag tells software it may write the next character, and it can raise an interrupt. A shift-empty flag, which raises no interrupt, shows when the line has finished. An optional ninth data bit is staged in its own control register before the low byte is written. A polarity control inverts every line level, including idle.

The block transmits only while the port is enabled, the transmitter is enabled and synchronous mode is deselected. Leaving that state aborts any frame in progress and discards the held character.

Top module: `sertx_top`

## Requirements
- R1: After reset, with the transmitter not enabled, `tx_o` is 1, `shift_empty_o` is 1, `hold_empty_o` is 0 and `irq_o` is 0.
- R2: `hold_empty_o` is 1 exactly when the block is active (`port_en_i`=1, `tx_en_i`=1, `sync_sel_i`=0) and the holding register holds no character. It reads 0 whenever the block is inactive.
- R3: A `wr_i` pulse that is accepted at clock edge k drives `hold_empty_o` low after edge k. If the shifter is idle, the character enters the shifter at edge k+1: after that edge `shift_empty_o` is 0 and `hold_empty_o` is 1 again.
- R4: A frame is a start bit (0), then data bits from bit 0 upward, then a stop bit (1), at non-inverted polarity. The start bit appears at load. Each `baud_tick_i` pulse advances one bit. `shift_empty_o` returns to 1 on the tick that ends the stop bit.
- R5: When `wide_i`=1 at load, nine data bits are sent, and the staged ninth bit goes out as bit 8, between bit 7 and the stop bit.
- R6: A `ninth_we_i` pulse stores `ninth_i`. The stored value is captured together with the low byte at the accepted write. A later change of the staged bit does not alter a character already written.
- R7: When `invert_i`=1, every line level is inverted: idle and stop become 0, the start bit becomes 1, and data bits are complemented.
- R8: A write while the holding register is full is ignored: the held character is unchanged and is the one sent next.
- R9: A character waiting in the holding register moves into the shifter on the same edge as the tick that ends the previous stop bit. The new start bit follows with no idle gap, and `shift_empty_o` stays 0.
- R10: Making the block inactive aborts the frame in progress. After the next edge, `tx_o` is at idle level and `shift_empty_o` is 1, and any held character is discarded.
- R11: While `sync_sel_i`=1 or `port_en_i`=0, writes are ignored and no frame starts.
- R12: `irq_o` equals `hold_empty_o` AND `irq_en_i`. `shift_empty_o` never drives `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_en_i | input | 1 | Serial port enable |
| tx_en_i | input | 1 | Transmit enable |
| sync_sel_i | input | 1 | Synchronous mode select; transmitter runs only when 0 |
| wide_i | input | 1 | Nine-bit character mode |
| invert_i | input | 1 | Line polarity inversion |
| irq_en_i | input | 1 | Interrupt enable for holding-empty |
| baud_tick_i | input | 1 | One-cycle baud-rate enable, one pulse per bit |
| ninth_we_i | input | 1 | Write strobe for the staged ninth bit |
| ninth_i | input | 1 | Staged ninth bit value |
| wr_i | input | 1 | Write strobe for the low data byte |
| data_i | input | LOW_W | Low data byte |
| tx_o | output | 1 | Serial line |
| hold_empty_o | output | 1 | Holding register empty flag |
| shift_empty_o | output | 1 | Shift register empty flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a character waiting in the holding register at the exact edge on which the previous stop bit ends, together with a third write that arrives while the register is still full. The bench drives the baud enable by hand, one pulse at a time. It queues a second character just after the first one loads and tries a third write straight away. It then steps the line until the tick that ends the stop bit and checks on that edge that the queued character's start bit follows with no gap and that its bits, not those of the dropped write, appear. Aborts are created the same way: a frame is stopped mid-character with a character still queued.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned CHAR_LOW_W = 8;

  // bits on the line per character: start + data (+ninth) + stop
  function automatic int unsigned frame_bits(input logic wide, input int unsigned low_w);
    return wide ? low_w + 3 : low_w + 2;
  endfunction
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int unsigned LOW_W = sertx_pkg::CHAR_LOW_W,
  localparam int unsigned WORD_W = LOW_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              ninth_we_i,
  input  logic              ninth_i,
  input  logic              wr_i,
  input  logic [LOW_W-1:0]  data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [WORD_W-1:0] word_o
);
  logic              ninth_q;
  logic              full_q;
  logic [WORD_W-1:0] word_q;
  logic              accept;

  assign accept = wr_i & active_i & ~full_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ninth_q <= 1'b0;
    else if (ninth_we_i) ninth_q <= ninth_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else if (!active_i) begin
      full_q <= 1'b0;
    end else if (accept) begin
      full_q <= 1'b1;
      word_q <= {ninth_q, data_i};
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign word_o = word_q;

  // R8: a write into a full register that is not draining leaves it untouched
  a_r8_full_write_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_q && wr_i && active_i && !take_i |=> full_q && $stable(word_q));
  // R3: transfer empties the holding register
  a_r3_take_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> !full_q);
  // R10: inactive flushes the holding register
  a_r10_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !full_q);
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift #(
  parameter int unsigned LOW_W = sertx_pkg::CHAR_LOW_W,
  localparam int unsigned WORD_W  = LOW_W + 1,
  localparam int unsigned FRAME_W = LOW_W + 3,
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              tick_i,
  input  logic              wide_i,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              busy_o,
  output logic              ready_o,
  output logic              line_o
);
  logic               busy_q;
  logic [FRAME_W-1:0] frame_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               finish;
  logic [FRAME_W-1:0] frame_new;
  logic [CNT_W-1:0]   cnt_new;

  assign finish  = busy_q & tick_i & (cnt_q == CNT_W'(1));
  assign ready_o = ~busy_q | finish;

  // stop, optional ninth (stop level when narrow), low byte, start
  assign frame_new = {1'b1, wide_i ? word_i[LOW_W] : 1'b1, word_i[LOW_W-1:0], 1'b0};
  assign cnt_new   = CNT_W'(sertx_pkg::frame_bits(wide_i, LOW_W));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      cnt_q   <= '0;
    end else if (!active_i) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      cnt_q   <= '0;
    end else if (load_i) begin
      busy_q  <= 1'b1;
      frame_q <= frame_new;
      cnt_q   <= cnt_new;
    end else if (finish) begin
      busy_q  <= 1'b0;
      frame_q <= '1;
      cnt_q   <= '0;
    end else if (busy_q && tick_i) begin
      frame_q <= {1'b1, frame_q[FRAME_W-1:1]};
      cnt_q   <= cnt_q - CNT_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign line_o = frame_q[0];

  // R4: load starts a frame with the start level
  a_r4_load_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i && load_i |=> busy_q && !line_o);
  // R4: bit counter stays inside the frame length while busy
  a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (cnt_q != '0) && (cnt_q <= CNT_W'(FRAME_W)));
  // R4: idle line rests at the stop level
  a_r4_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> line_o);
  // R10: inactive aborts the frame
  a_r10_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !busy_q);
  // R4: line holds between ticks
  a_r4_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !tick_i && active_i |=> $stable(line_o));
endmodule

// File: rtl/sertx_pol.sv
module sertx_pol #(
  parameter bit REG_OUT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  input  logic invert_i,
  output logic tx_o
);
  generate
    if (REG_OUT) begin : g_reg
      logic tx_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tx_q <= 1'b1;
        else         tx_q <= line_i ^ invert_i;
      end
      assign tx_o = tx_q;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk_i & rst_ni;
      assign tx_o = line_i ^ invert_i;
    end
  endgenerate
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int unsigned LOW_W   = sertx_pkg::CHAR_LOW_W,
  parameter bit          REG_OUT = 1'b0,
  localparam int unsigned WORD_W = LOW_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             port_en_i,
  input  logic             tx_en_i,
  input  logic             sync_sel_i,
  input  logic             wide_i,
  input  logic             invert_i,
  input  logic             irq_en_i,
  input  logic             baud_tick_i,
  input  logic             ninth_we_i,
  input  logic             ninth_i,
  input  logic             wr_i,
  input  logic [LOW_W-1:0] data_i,
  output logic             tx_o,
  output logic             hold_empty_o,
  output logic             shift_empty_o,
  output logic             irq_o
);
  logic              active;
  logic              full;
  logic [WORD_W-1:0] word;
  logic              take;
  logic              busy;
  logic              ready;
  logic              line;

  assign active = port_en_i & tx_en_i & ~sync_sel_i;
  assign take   = full & ready & active;

  sertx_hold #(.LOW_W(LOW_W)) i_hold (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .ninth_we_i (ninth_we_i),
    .ninth_i    (ninth_i),
    .wr_i       (wr_i),
    .data_i     (data_i),
    .take_i     (take),
    .full_o     (full),
    .word_o     (word)
  );

  sertx_shift #(.LOW_W(LOW_W)) i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (active),
    .tick_i   (baud_tick_i),
    .wide_i   (wide_i),
    .load_i   (take),
    .word_i   (word),
    .busy_o   (busy),
    .ready_o  (ready),
    .line_o   (line)
  );

  sertx_pol #(.REG_OUT(REG_OUT)) i_pol (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .line_i   (line),
    .invert_i (invert_i),
    .tx_o     (tx_o)
  );

  assign hold_empty_o  = active & ~full;
  assign shift_empty_o = ~busy;
  assign irq_o         = hold_empty_o & irq_en_i;

  // R12: interrupt only with holding-empty
  a_r12_irq_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> hold_empty_o && irq_en_i);
  // R11: inactive never reports holding-empty
  a_r11_inactive_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !hold_empty_o);
  // R3: an accepted write clears holding-empty on the next cycle
  a_r3_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_empty_o && wr_i && active |=> !hold_empty_o);
  // R9: queued character refills the shifter when the frame ends
  a_r9_back_to_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && full && active && ready |=> !shift_empty_o);
endmodule

// File: tb/test_sertx_top.sv
`timescale 1ns/1ps
module test_sertx_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       port_en = 1'b0, tx_en = 1'b0, sync_sel = 1'b0;
  logic       wide = 1'b0, invert = 1'b0, irq_en = 1'b0;
  logic       tick = 1'b0, ninth_we = 1'b0, ninth = 1'b0, wr = 1'b0;
  logic [7:0] data = '0;
  logic       tx, hold_empty, shift_empty, irq;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  sertx_top i_sertx_top (
    .clk_i(clk), .rst_ni(rst_ni), .port_en_i(port_en), .tx_en_i(tx_en),
    .sync_sel_i(sync_sel), .wide_i(wide), .invert_i(invert), .irq_en_i(irq_en),
    .baud_tick_i(tick), .ninth_we_i(ninth_we), .ninth_i(ninth), .wr_i(wr),
    .data_i(data), .tx_o(tx), .hold_empty_o(hold_empty),
    .shift_empty_o(shift_empty), .irq_o(irq)
  );

  // {wide, invert, ninth, data}
  localparam logic [10:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b0, 8'hA5},
    {1'b0, 1'b0, 1'b0, 8'h00},
    {1'b0, 1'b1, 1'b0, 8'h3C},
    {1'b1, 1'b0, 1'b1, 8'h5A},
    {1'b1, 1'b1, 1'b0, 8'hFF},
    {1'b1, 1'b0, 1'b0, 8'h81}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic baud();
    tick = 1'b1;
    step();
    tick = 1'b0;
  endtask

  task automatic stage(input logic v);
    ninth_we = 1'b1; ninth = v;
    step();
    ninth_we = 1'b0;
  endtask

  task automatic write(input logic [7:0] d);
    wr = 1'b1; data = d;
    step();
    wr = 1'b0;
  endtask

  task automatic frame(input logic w, input logic inv, input logic n9, input logic [7:0] d);
    logic [8:0] bits;
    wide = w; invert = inv;
    bits = {n9, d};
    stage(n9);
    write(d);
    chk("R3 hold_empty low after write", hold_empty, 1'b0);
    step();
    chk("R3 hold_empty back high", hold_empty, 1'b1);
    chk("R3 shift_empty low", shift_empty, 1'b0);
    chk("R4/R7 start bit", tx, inv);
    for (int i = 0; i < (w ? 9 : 8); i++) begin
      baud();
      chk(i == 8 ? "R5 ninth bit" : "R4/R7 data bit", tx, inv ^ bits[i]);
    end
    baud();
    chk("R4/R7 stop bit", tx, ~inv);
    chk("R4 busy in stop", shift_empty, 1'b0);
    baud();
    chk("R4 shift_empty after stop", shift_empty, 1'b1);
    chk("R7 idle level", tx, ~inv);
  endtask

  initial begin
    repeat (2) step();
    // R1 reset state
    chk("R1 tx idle", tx, 1'b1);
    chk("R1 shift_empty", shift_empty, 1'b1);
    chk("R1 hold_empty", hold_empty, 1'b0);
    chk("R1 irq", irq, 1'b0);
    rst_ni = 1'b1;
    step();
    chk("R2 inactive hold_empty", hold_empty, 1'b0);
    port_en = 1'b1; tx_en = 1'b1; irq_en = 1'b1;
    step();
    chk("R2 enabled hold_empty", hold_empty, 1'b1);
    chk("R12 irq on hold_empty", irq, 1'b1);
    irq_en = 1'b0;
    step();
    chk("R12 irq masked", irq, 1'b0);

    foreach (VEC[k]) frame(VEC[k][10], VEC[k][9], VEC[k][8], VEC[k][7:0]);
    invert = 1'b0;

    // R6: staged bit captured at write, later restage ignored
    wide = 1'b1;
    stage(1'b1);
    wr = 1'b1; data = 8'h00;
    step();
    wr = 1'b0; ninth_we = 1'b1; ninth = 1'b0;
    step();
    ninth_we = 1'b0;
    for (int i = 0; i < 9; i++) baud();
    chk("R6 ninth captured at write", tx, 1'b1);
    baud(); baud();
    chk("R6 frame end", shift_empty, 1'b1);

    // R8/R9: queued character and dropped write
    wide = 1'b0;
    write(8'h0F);
    step();
    write(8'hF0);
    chk("R9 queued hold_empty low", hold_empty, 1'b0);
    write(8'hAA);
    chk("R8 full write hold_empty low", hold_empty, 1'b0);
    for (int i = 0; i < 9; i++) baud();
    chk("R9 first stop bit", tx, 1'b1);
    baud();
    chk("R9 no gap shift_empty", shift_empty, 1'b0);
    chk("R9 next start bit", tx, 1'b0);
    chk("R9 hold_empty after refill", hold_empty, 1'b1);
    for (int i = 0; i < 8; i++) begin
      baud();
      chk("R8 held byte kept", tx, 8'hF0 >> i);
    end
    baud(); baud();
    chk("R8 dropped write not sent", shift_empty, 1'b1);
    step();
    chk("R8 nothing queued", shift_empty, 1'b1);

    // R10: abort mid-frame with a queued character
    write(8'h00);
    step();
    write(8'h55);
    baud(); baud();
    chk("R10 mid-frame low", tx, 1'b0);
    tx_en = 1'b0;
    step();
    chk("R10 abort shift_empty", shift_empty, 1'b1);
    chk("R10 abort idle line", tx, 1'b1);
    chk("R10 inactive hold_empty", hold_empty, 1'b0);
    tx_en = 1'b1;
    step(); step();
    chk("R10 queued discarded", shift_empty, 1'b1);
    chk("R10 holding empty after abort", hold_empty, 1'b1);

    // R11: synchronous select and port disable block writes
    sync_sel = 1'b1;
    step();
    chk("R11 sync hold_empty", hold_empty, 1'b0);
    write(8'h55);
    sync_sel = 1'b0;
    step();
    chk("R11 sync write ignored", shift_empty, 1'b1);
    chk("R11 sync hold_empty back", hold_empty, 1'b1);
    port_en = 1'b0;
    write(8'h55);
    port_en = 1'b1;
    step();
    chk("R11 port off write ignored", shift_empty, 1'b1);
    chk("R11 line idle", tx, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule